// File: doc/BRIEF.md
# Separable Bicubic Interpolation Filter

This block produces one resampled 8-bit pixel from a 4x4 neighbourhood of input pixels and a fractional sample position. The interpolation is separable. Each of the four rows is first filtered with a four-tap cubic kernel whose weights are chosen by the horizontal phase. The four row results are then filtered with the same kind of kernel, this time weighted by the vertical phase. Both passes start their accumulation from a rounding constant and end with an arithmetic right shift. The final value is clamped into the pixel range.

The datapath is a fixed four-stage pipeline. It accepts a new neighbourhood on every clock cycle. A valid flag travels beside the data. Cycles with the input valid flag low leave the output register unchanged. Address generation, scale stepping and frame storage sit outside the block. Surrounding logic places the neighbourhood and the two phases on the inputs.

Top module: `bicubic_interp`

## Requirements
- R1: While `rst_n` is low and after its release, `outValid` is 0 and `outPix` is 0 until the first result arrives.
- R2: A phase value p (4 bits, sample position t = p/16) selects four signed 8-bit weights with 6 fractional bits. The weights are w0 = floor((-p^3 + 32p^2 - 256p + 64)/128), w2 = floor((-3p^3 + 64p^2 + 256p + 64)/128), w3 = floor((p^3 - 16p^2 + 64)/128) and w1 = 64 - w0 - w2 - w3, so the four always sum to 64.
- R3: Row r of the neighbourhood is the pixel at `inPix[(4r+c)*8 +: 8]` for columns c = 0..3, with row 0 at the top and column 0 at the left. Its horizontal result is h_r = floor((32 + sum over c of wx_c * pixel[r][c]) / 64), kept signed and unclamped, where wx comes from `phaseX` per R2.
- R4: The vertical result is v = floor((32 + sum over r of wy_r * h_r) / 64), where wy comes from `phaseY` per R2. When v lies in 0..255, `outPix` equals v.
- R5: A vertical result below 0 gives `outPix` = 0, and one above 255 gives `outPix` = 255.
- R6: A neighbourhood captured with `inValid` high at a rising clock edge appears on `outPix`, with `outValid` high, right after the fourth rising edge from that one. Back-to-back inputs give back-to-back outputs, and `outValid` is low for every other cycle.
- R7: While `inValid` is low, the pixel and phase inputs are ignored, and `outPix` keeps the last result.
- R8: With both phases 0, the output equals the pixel at row 1, column 1. A neighbourhood of 16 equal pixels yields that same value for any phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Neighbourhood and phases are valid this cycle |
| inPix | input | 128 | 16 unsigned pixels, row-major, row 0 column 0 in the low byte |
| phaseX | input | 4 | Horizontal fractional phase |
| phaseY | input | 4 | Vertical fractional phase |
| outValid | output | 1 | `outPix` carries a new result |
| outPix | output | 8 | Interpolated, clamped output pixel |

## Verification
Every result is due four rising edges after the edge that captured its neighbourhood. The bench drives each input at a falling edge and inspects the outputs at falling edges, with the expectation lined up four cycles after its stimulus. The same index shift applies to the valid flag. Cycles with no valid input are expected to show `outValid` low and the previous pixel held. Because of this, gaps in the input stream check the hold behaviour and the latency at the same time.

// File: rtl/bicubic_pkg.sv
package bicubic_pkg;

  localparam int STAGES = 4;   // fixed pipeline depth
  localparam int TAPS   = 4;   // kernel length per axis

  // Load strobes handed from the control to the datapath, one per stage.
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
  } stageStrobe_t;

  function automatic longint floorDiv(longint num, longint den);
    longint q;
    q = num / den;
    if ((num % den != 0) && (num < 0)) q = q - 1;
    return q;
  endfunction

  // Cubic convolution weight (kernel parameter -1/2) for a phase and tap,
  // scaled by 2**frac and rounded to nearest; tap 1 absorbs the residue.
  function automatic int cubicWeight(int phase, int tap, int phaseW, int frac);
    longint n, s, p, d, num0, num2, num3;
    int w0, w2, w3;
    n = longint'(1) << phaseW;
    s = longint'(1) << frac;
    p = longint'(phase);
    d = 2 * n * n * n;
    num0 = s * (-p * p * p + 2 * p * p * n - p * n * n);
    num2 = s * (-3 * p * p * p + 4 * p * p * n + p * n * n);
    num3 = s * (p * p * p - p * p * n);
    w0 = int'(floorDiv(num0 + d / 2, d));
    w2 = int'(floorDiv(num2 + d / 2, d));
    w3 = int'(floorDiv(num3 + d / 2, d));
    case (tap)
      0:       return w0;
      1:       return int'(s) - w0 - w2 - w3;
      2:       return w2;
      default: return w3;
    endcase
  endfunction

endpackage

// File: rtl/bicubic_coef.sv
module bicubic_coef
  import bicubic_pkg::*;
#(
  parameter int PHASE_W   = 4,
  parameter int COEF_W    = 8,
  parameter int COEF_FRAC = 6
) (
  input  logic        [PHASE_W-1:0] phase,
  output logic signed [COEF_W-1:0]  weight [TAPS]
);

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      weight[k] = COEF_W'(cubicWeight(int'(phase), k, PHASE_W, COEF_FRAC));
    end
  end

endmodule

// File: rtl/bicubic_tap4.sv
module bicubic_tap4
  import bicubic_pkg::*;
#(
  parameter int IN_W   = 9,
  parameter int COEF_W = 8,
  parameter int FRAC   = 6,
  parameter int OUT_W  = 11
) (
  input  logic signed [IN_W-1:0]   sample [TAPS],
  input  logic signed [COEF_W-1:0] coef   [TAPS],
  output logic signed [OUT_W-1:0]  result
);

  localparam int ACC_W = IN_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1 << (FRAC - 1));

  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc = ROUND;
    for (int k = 0; k < TAPS; k++) begin
      acc = acc + ACC_W'(sample[k]) * ACC_W'(coef[k]);
    end
    result = OUT_W'(acc >>> FRAC);
  end

endmodule

// File: rtl/bicubic_ctrl.sv
module bicubic_ctrl
  import bicubic_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output stageStrobe_t strobes,
  output logic         outValid
);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validPipe <= '0;
    else        validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobes.ld1 = inValid;
    strobes.ld2 = validPipe[0];
    strobes.ld3 = validPipe[1];
    strobes.ld4 = validPipe[2];
    outValid    = validPipe[STAGES-1];
  end

  // R6: a valid output traces back to a valid input four edges earlier
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid, STAGES));

  // R6: the last load strobe is followed by a valid flag
  assert_last_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ld4 |=> outValid);

endmodule

// File: rtl/bicubic_datapath.sv
module bicubic_datapath
  import bicubic_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int PHASE_W   = 4,
  parameter int COEF_W    = 8,
  parameter int COEF_FRAC = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  stageStrobe_t                st,
  input  logic [TAPS*TAPS*PIX_W-1:0]  inPix,
  input  logic [PHASE_W-1:0]          phaseX,
  input  logic [PHASE_W-1:0]          phaseY,
  output logic [PIX_W-1:0]            outPix
);

  localparam int NPIX  = TAPS * TAPS;
  localparam int SIN_W = PIX_W + 1;   // pixel as a signed sample
  localparam int H_W   = PIX_W + 3;   // horizontal intermediate
  localparam int V_W   = H_W + 1;     // vertical result before clamping
  localparam logic signed [V_W-1:0] PIX_MAX = V_W'((1 << PIX_W) - 1);
  localparam int ONE = 1 << COEF_FRAC;

  logic signed [COEF_W-1:0] wxNext [TAPS];
  logic signed [COEF_W-1:0] wyNext [TAPS];

  logic        [PIX_W-1:0]  pixReg [NPIX];
  logic signed [COEF_W-1:0] wxReg  [TAPS];
  logic signed [COEF_W-1:0] wyReg  [TAPS];

  logic signed [H_W-1:0]    hNext  [TAPS];
  logic signed [H_W-1:0]    hReg   [TAPS];
  logic signed [COEF_W-1:0] wyReg2 [TAPS];

  logic signed [V_W-1:0]    vNext;
  logic signed [V_W-1:0]    vReg;

  bicubic_coef #(.PHASE_W(PHASE_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) i_coefX (
    .phase  (phaseX),
    .weight (wxNext)
  );

  bicubic_coef #(.PHASE_W(PHASE_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) i_coefY (
    .phase  (phaseY),
    .weight (wyNext)
  );

  // Stage 1: capture neighbourhood and both weight sets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) pixReg[i] <= '0;
      for (int k = 0; k < TAPS; k++) begin
        wxReg[k] <= '0;
        wyReg[k] <= '0;
      end
    end else if (st.ld1) begin
      for (int i = 0; i < NPIX; i++) pixReg[i] <= inPix[i*PIX_W +: PIX_W];
      for (int k = 0; k < TAPS; k++) begin
        wxReg[k] <= wxNext[k];
        wyReg[k] <= wyNext[k];
      end
    end
  end

  // Horizontal pass: one four-tap filter per row
  for (genvar r = 0; r < TAPS; r++) begin : g_row
    logic signed [SIN_W-1:0] rowSample [TAPS];

    always_comb begin
      for (int c = 0; c < TAPS; c++) begin
        rowSample[c] = signed'({1'b0, pixReg[r*TAPS + c]});
      end
    end

    bicubic_tap4 #(.IN_W(SIN_W), .COEF_W(COEF_W), .FRAC(COEF_FRAC), .OUT_W(H_W)) i_hTap (
      .sample (rowSample),
      .coef   (wxReg),
      .result (hNext[r])
    );
  end

  // Stage 2: row results and the vertical weights that go with them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        hReg[k]   <= '0;
        wyReg2[k] <= '0;
      end
    end else if (st.ld2) begin
      for (int k = 0; k < TAPS; k++) begin
        hReg[k]   <= hNext[k];
        wyReg2[k] <= wyReg[k];
      end
    end
  end

  // Vertical pass over the four row results
  bicubic_tap4 #(.IN_W(H_W), .COEF_W(COEF_W), .FRAC(COEF_FRAC), .OUT_W(V_W)) i_vTap (
    .sample (hReg),
    .coef   (wyReg2),
    .result (vNext)
  );

  // Stage 3: vertical result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vReg <= '0;
    else if (st.ld3) vReg <= vNext;
  end

  // Stage 4: clamp into the pixel range
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outPix <= '0;
    end else if (st.ld4) begin
      if (vReg < 0)             outPix <= '0;
      else if (vReg > PIX_MAX)  outPix <= '1;
      else                      outPix <= vReg[PIX_W-1:0];
    end
  end

  // R2: the horizontal weights in flight sum to unity
  assert_coef_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st.ld2 |-> (int'(wxReg[0]) + int'(wxReg[1]) + int'(wxReg[2]) + int'(wxReg[3]) == ONE));

  // R4: an in-range vertical result passes through unchanged
  assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st.ld4 && vReg >= 0 && vReg <= PIX_MAX) |=> outPix == $past(vReg[PIX_W-1:0]));

  // R5: overshoot saturates to full scale
  assert_clamp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.ld4 && vReg > PIX_MAX) |=> outPix == '1);

  // R5: undershoot saturates to zero
  assert_clamp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.ld4 && vReg < 0) |=> outPix == '0);

  // R7: no final load, no change on the output
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !st.ld4 |=> $stable(outPix));

endmodule

// File: rtl/bicubic_interp.sv
module bicubic_interp
  import bicubic_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int PHASE_W   = 4,
  parameter int COEF_W    = 8,
  parameter int COEF_FRAC = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  input  logic [TAPS*TAPS*PIX_W-1:0] inPix,
  input  logic [PHASE_W-1:0]         phaseX,
  input  logic [PHASE_W-1:0]         phaseY,
  output logic                       outValid,
  output logic [PIX_W-1:0]           outPix
);

  stageStrobe_t strobes;

  bicubic_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bicubic_datapath #(
    .PIX_W     (PIX_W),
    .PHASE_W   (PHASE_W),
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC)
  ) i_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (strobes),
    .inPix  (inPix),
    .phaseX (phaseX),
    .phaseY (phaseY),
    .outPix (outPix)
  );

endmodule

// File: tb/test_bicubic_interp.sv
`timescale 1ns/100ps
module test_bicubic_interp;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] inPix = '0;
  logic [3:0]   phaseX = '0;
  logic [3:0]   phaseY = '0;
  logic         outValid;
  logic [7:0]   outPix;

  int vectors = 0;
  int failures = 0;
  bit finished = 0;

  // Stimulus slots for one stream
  logic [7:0] sPix [64][16];
  int         sPx  [64];
  int         sPy  [64];
  bit         sVal [64];
  int         sExp [64];
  string      sTag [64];
  int         lastExp = 0;

  always #2.5 clk = ~clk;

  bicubic_interp i_bicubic_interp (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inPix    (inPix),
    .phaseX   (phaseX),
    .phaseY   (phaseY),
    .outValid (outValid),
    .outPix   (outPix)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Weight per R2, written directly from the requirement
  function automatic int benchWeight(int p, int k);
    int a, b, d;
    a = (-p*p*p + 32*p*p - 256*p + 64) >>> 7;
    b = (-3*p*p*p + 64*p*p + 256*p + 64) >>> 7;
    d = (p*p*p - 16*p*p + 64) >>> 7;
    case (k)
      0: return a;
      1: return 64 - a - b - d;
      2: return b;
      default: return d;
    endcase
  endfunction

  // Expected output per R3, R4, R5
  function automatic int model(int j);
    int h [4];
    int v;
    for (int r = 0; r < 4; r++) begin
      int s = 32;
      for (int c = 0; c < 4; c++) s += benchWeight(sPx[j], c) * int'(sPix[j][r*4+c]);
      h[r] = s >>> 6;
    end
    v = 32;
    for (int r = 0; r < 4; r++) v += benchWeight(sPy[j], r) * h[r];
    v = v >>> 6;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic fillRandom(int j, bit valid, int px, int py);
    for (int i = 0; i < 16; i++) sPix[j][i] = 8'($urandom_range(0, 255));
    sPx[j] = px;
    sPy[j] = py;
    sVal[j] = valid;
  endtask

  task automatic fillRows(int j, int c0, int c1, int c2, int c3, int px, int py);
    for (int r = 0; r < 4; r++) begin
      sPix[j][r*4+0] = 8'(c0);
      sPix[j][r*4+1] = 8'(c1);
      sPix[j][r*4+2] = 8'(c2);
      sPix[j][r*4+3] = 8'(c3);
    end
    sPx[j] = px;
    sPy[j] = py;
    sVal[j] = 1'b1;
  endtask

  // Drive n slots on falling edges; results are checked four cycles later (R6)
  task automatic runStream(int n);
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (i >= 4 && sVal[i-4]) begin
        chk({"R6 valid ", sTag[i-4]}, int'(outValid), 1);
        chk(sTag[i-4], int'(outPix), sExp[i-4]);
        lastExp = sExp[i-4];
      end else begin
        chk("R6 no valid", int'(outValid), 0);
        chk("R7 hold", int'(outPix), lastExp);
      end
      if (i < n) begin
        for (int k = 0; k < 16; k++) inPix[k*8 +: 8] = sPix[i][k];
        phaseX  = 4'(sPx[i]);
        phaseY  = 4'(sPy[i]);
        inValid = sVal[i];
      end else begin
        inValid = 1'b0;
      end
    end
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    inValid = 1'b1;
    inPix = {16{8'hA5}};
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(outValid), 0);
    chk("R1 pixel in reset", int'(outPix), 0);
    inValid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(outValid), 0);
    chk("R1 pixel after reset", int'(outPix), 0);
    lastExp = 0;
  endtask

  task automatic testIdentity();
    for (int j = 0; j < 6; j++) begin
      fillRandom(j, 1'b1, 0, 0);
      sExp[j] = int'(sPix[j][5]);
      sTag[j] = "R8 phase zero";
    end
    runStream(6);
  endtask

  task automatic testConstant();
    for (int j = 0; j < 6; j++) begin
      int v = (j == 0) ? 0 : ((j == 1) ? 255 : $urandom_range(0, 255));
      fillRows(j, v, v, v, v, $urandom_range(0, 15), $urandom_range(0, 15));
      sExp[j] = v;
      sTag[j] = "R8 flat patch";
    end
    runStream(6);
  endtask

  task automatic testClamp();
    fillRows(0, 0, 255, 255, 0, 8, 8);
    sExp[0] = 255; sTag[0] = "R5 overshoot";
    fillRows(1, 255, 0, 0, 255, 8, 8);
    sExp[1] = 0;   sTag[1] = "R5 undershoot";
    fillRows(2, 0, 255, 255, 0, 8, 0);
    sExp[2] = 255; sTag[2] = "R5 overshoot row only";
    fillRows(3, 255, 0, 0, 255, 4, 12);
    sExp[3] = model(3); sTag[3] = "R5 undershoot off-centre";
    runStream(4);
  endtask

  task automatic testRandomStream();
    for (int j = 0; j < 40; j++) begin
      fillRandom(j, ($urandom_range(0, 3) != 0), $urandom_range(0, 15), $urandom_range(0, 15));
      sExp[j] = model(j);
      sTag[j] = "R2 R3 R4 random";
    end
    runStream(40);
  endtask

  task automatic testIgnoreWhenIdle();
    fillRows(0, 10, 20, 30, 40, 0, 0);
    sExp[0] = 20; sTag[0] = "R7 seed";
    for (int j = 1; j < 8; j++) begin
      fillRandom(j, 1'b0, $urandom_range(0, 15), $urandom_range(0, 15));
      sTag[j] = "R7 ignored";
    end
    runStream(8);
  endtask

  initial begin
    testReset();
    testIdentity();
    testConstant();
    testClamp();
    testRandomStream();
    testIgnoreWhenIdle();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

endmodule